// File: doc/BRIEF.md
# Stream Entry Configuration Checker

This block sits between the stream-table fetch logic and the stage-1 walker of an I/O address translation unit. It receives one fetched stream table entry as a single parallel word. From that word it decides how the translation proceeds. There are four possible verdicts: abort silently, bypass (the address passes through untranslated), continue to stage-1 translation, or raise a bad-entry configuration fault.

A request is offered with `req_valid` and is taken only while `req_ready` is high, that is, while no response is being presented. One clock later the verdict appears for exactly one cycle with `rsp_valid`. The response carries the verdict, a fault reason, an event code and the accepted entry word, so that a stage-1 walker downstream can read its context pointer. Stage-2 translation, multiple context descriptors and the stall fault model are not implemented. An entry that asks for any of them is reported as bad.

Top module: `ste_cfg_check`

## Requirements
- R1: While reset (`rst_n` low) is applied, and right after it is released, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. Its response is presented after that edge with `rsp_valid` high for exactly one cycle. During that cycle `req_ready` is 0. A request held high therefore gets a response every other cycle.
- R3: An entry whose valid bit (entry bit 0) is 0 gives outcome FAULT (2'd3), reason INVALID (3'd1) and event code 0x04, whatever its configuration field holds.
- R4: A valid entry whose 3-bit configuration field (entry bits [3:1]) is 3'b000 gives outcome ABORT (2'd0), reason 0 and event code 0. The max-context count and the stall bit are ignored.
- R5: A valid entry with configuration 3'b100 gives outcome BYPASS (2'd1), reason 0 and event code 0. The max-context count and the stall bit are ignored.
- R6: A valid entry whose configuration has bit 1 set (the stage-2 enable) gives FAULT, reason STAGE2 (3'd2) and event 0x04.
- R7: A valid stage-1 entry with a nonzero max-context-descriptor count (entry bits [40:36]) gives FAULT, reason MULTICD (3'd3) and event 0x04.
- R8: A valid stage-1 entry with the stall-disable bit (entry bit 91) set gives FAULT, reason STALL (3'd4) and event 0x04.
- R9: When several defects are present, the reason is chosen in the order INVALID, then STAGE2, then MULTICD, then STALL.
- R10: A valid entry with configuration 3'b001 or 3'b101 and none of the defects above gives outcome STAGE1 (2'd2), reason 0 and event 0.
- R11: A request raised while `req_ready` is 0 is not accepted: `rsp_valid` is 0 in the following cycle.
- R12: `rsp_entry` equals the accepted entry word while `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Entry offered |
| req_ready | output | 1 | Block idle, entry can be taken |
| req_entry | input | ENTRY_W (128) | Fetched stream table entry |
| rsp_valid | output | 1 | Verdict valid, one cycle |
| rsp_outcome | output | 2 | 0 abort, 1 bypass, 2 stage-1, 3 fault |
| rsp_reason | output | 3 | 0 none, 1 invalid, 2 stage-2, 3 multi-context, 4 stall |
| rsp_event | output | EVT_W (8) | 0x04 for a bad entry, else 0 |
| rsp_entry | output | ENTRY_W (128) | Accepted entry word |

## Verification
The bench aims at the ordering of checks. An invalid entry that carries the abort or bypass code must still fault. If abort were decoded before validity, that entry would vanish silently. Bypass and abort entries are given nonzero context counts and stall bits: a design that checked those defects too early would fault on them. Entries with several defects at once expose a wrong reason priority. A request held high across a busy cycle would produce back-to-back responses if the busy state were not honoured.

// File: rtl/ste_chk_pkg.sv
package ste_chk_pkg;

  localparam int CFG_W = 3;
  localparam int OC_W  = 2;
  localparam int RS_W  = 3;

  localparam logic [OC_W-1:0] OC_ABORT  = 2'd0;
  localparam logic [OC_W-1:0] OC_BYPASS = 2'd1;
  localparam logic [OC_W-1:0] OC_STAGE1 = 2'd2;
  localparam logic [OC_W-1:0] OC_FAULT  = 2'd3;

  localparam logic [RS_W-1:0] RS_NONE    = 3'd0;
  localparam logic [RS_W-1:0] RS_INVALID = 3'd1;
  localparam logic [RS_W-1:0] RS_STAGE2  = 3'd2;
  localparam logic [RS_W-1:0] RS_MULTICD = 3'd3;
  localparam logic [RS_W-1:0] RS_STALL   = 3'd4;

  localparam logic [CFG_W-1:0] CFG_ABORT  = 3'b000;
  localparam logic [CFG_W-1:0] CFG_BYPASS = 3'b100;
  localparam int               CFG_S2_BIT = 1;

  typedef struct packed {
    logic [OC_W-1:0] oc;
    logic [RS_W-1:0] rs;
  } verdict_t;

  // Ordered decision: validity, abort, bypass, stage-2, context count, stall.
  function automatic verdict_t judge(input logic vld, input logic [CFG_W-1:0] cfg,
                                     input logic cd_nz, input logic stall);
    verdict_t v;
    v.oc = OC_FAULT;
    v.rs = RS_NONE;
    if (!vld)                    v.rs = RS_INVALID;
    else if (cfg == CFG_ABORT)   v.oc = OC_ABORT;
    else if (cfg == CFG_BYPASS)  v.oc = OC_BYPASS;
    else if (cfg[CFG_S2_BIT])    v.rs = RS_STAGE2;
    else if (cd_nz)              v.rs = RS_MULTICD;
    else if (stall)              v.rs = RS_STALL;
    else                         v.oc = OC_STAGE1;
    return v;
  endfunction

endpackage

// File: rtl/ste_rule_eval.sv
module ste_rule_eval
  import ste_chk_pkg::*;
#(
  parameter int                CDMAX_W = 5,
  parameter int                EVT_W   = 8,
  parameter logic [EVT_W-1:0]  EVT_BAD = 8'h04
) (
  input  logic               ent_vld,
  input  logic [CFG_W-1:0]   ent_cfg,
  input  logic [CDMAX_W-1:0] ent_cdmax,
  input  logic               ent_stalld,
  output logic [OC_W-1:0]    oc,
  output logic [RS_W-1:0]    rs,
  output logic [EVT_W-1:0]   evt,
  output logic               abort_hit,
  output logic               bypass_hit
);

  verdict_t v;

  always_comb begin
    v          = judge(ent_vld, ent_cfg, |ent_cdmax, ent_stalld);
    oc         = v.oc;
    rs         = v.rs;
    evt        = (v.oc == OC_FAULT) ? EVT_BAD : '0;
    abort_hit  = (v.oc == OC_ABORT);
    bypass_hit = (v.oc == OC_BYPASS);
  end

endmodule

// File: rtl/ste_resp_reg.sv
module ste_resp_reg
  import ste_chk_pkg::*;
#(
  parameter int ENTRY_W = 128,
  parameter int EVT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [OC_W-1:0]    oc_in,
  input  logic [RS_W-1:0]    rs_in,
  input  logic [EVT_W-1:0]   evt_in,
  input  logic [ENTRY_W-1:0] entry_in,
  output logic               busy,
  output logic               rsp_valid,
  output logic [OC_W-1:0]    rsp_oc,
  output logic [RS_W-1:0]    rsp_rs,
  output logic [EVT_W-1:0]   rsp_evt,
  output logic [ENTRY_W-1:0] rsp_entry
);

  logic vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q     <= 1'b0;
      rsp_oc    <= '0;
      rsp_rs    <= '0;
      rsp_evt   <= '0;
      rsp_entry <= '0;
    end else begin
      vld_q <= take;
      if (take) begin
        rsp_oc    <= oc_in;
        rsp_rs    <= rs_in;
        rsp_evt   <= evt_in;
        rsp_entry <= entry_in;
      end
    end
  end

  assign rsp_valid = vld_q;
  assign busy      = vld_q;

endmodule

// File: rtl/ste_cfg_check.sv
module ste_cfg_check
  import ste_chk_pkg::*;
#(
  parameter int               ENTRY_W    = 128,
  parameter int               VALID_BIT  = 0,
  parameter int               CFG_LSB    = 1,
  parameter int               CDMAX_LSB  = 36,
  parameter int               CDMAX_W    = 5,
  parameter int               STALLD_BIT = 91,
  parameter int               EVT_W      = 8,
  parameter logic [EVT_W-1:0] EVT_BAD    = 8'h04
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ENTRY_W-1:0] req_entry,
  output logic               rsp_valid,
  output logic [1:0]         rsp_outcome,
  output logic [2:0]         rsp_reason,
  output logic [EVT_W-1:0]   rsp_event,
  output logic [ENTRY_W-1:0] rsp_entry
);

  // Named internal events, observed by the bound checker.
  logic               take;
  logic               busy;
  logic               ent_vld;
  logic [CFG_W-1:0]   ent_cfg;
  logic [CDMAX_W-1:0] ent_cdmax;
  logic               ent_stalld;
  logic [OC_W-1:0]    oc_c;
  logic [RS_W-1:0]    rs_c;
  logic [EVT_W-1:0]   evt_c;
  logic               abort_hit;
  logic               bypass_hit;

  assign ent_vld    = req_entry[VALID_BIT];
  assign ent_cfg    = req_entry[CFG_LSB +: CFG_W];
  assign ent_cdmax  = req_entry[CDMAX_LSB +: CDMAX_W];
  assign ent_stalld = req_entry[STALLD_BIT];

  assign req_ready = !busy;
  assign take      = req_valid && !busy;

  ste_rule_eval #(
    .CDMAX_W (CDMAX_W),
    .EVT_W   (EVT_W),
    .EVT_BAD (EVT_BAD)
  ) u_rules (
    .ent_vld    (ent_vld),
    .ent_cfg    (ent_cfg),
    .ent_cdmax  (ent_cdmax),
    .ent_stalld (ent_stalld),
    .oc         (oc_c),
    .rs         (rs_c),
    .evt        (evt_c),
    .abort_hit  (abort_hit),
    .bypass_hit (bypass_hit)
  );

  ste_resp_reg #(
    .ENTRY_W (ENTRY_W),
    .EVT_W   (EVT_W)
  ) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .oc_in     (oc_c),
    .rs_in     (rs_c),
    .evt_in    (evt_c),
    .entry_in  (req_entry),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_oc    (rsp_outcome),
    .rsp_rs    (rsp_reason),
    .rsp_evt   (rsp_event),
    .rsp_entry (rsp_entry)
  );

endmodule

// File: rtl/ste_cfg_check_sva.sv
module ste_cfg_check_sva
  import ste_chk_pkg::*;
#(
  parameter int               EVT_W   = 8,
  parameter logic [EVT_W-1:0] EVT_BAD = 8'h04
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             take,
  input logic             ent_vld,
  input logic [CFG_W-1:0] ent_cfg,
  input logic             abort_hit,
  input logic             bypass_hit,
  input logic             rsp_valid,
  input logic [1:0]       rsp_outcome,
  input logic [2:0]       rsp_reason,
  input logic [EVT_W-1:0] rsp_event
);

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R2
  AST_ACCEPT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R2
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> !rsp_valid); // R11
  AST_INVALID_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ent_vld) |=> (rsp_outcome == OC_FAULT && rsp_reason == RS_INVALID)); // R3
  AST_FAULT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_outcome == OC_FAULT) |-> (rsp_event == EVT_BAD && rsp_reason != RS_NONE)); // R3
  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && abort_hit) |=> (rsp_outcome == OC_ABORT && rsp_event == '0)); // R4
  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && bypass_hit) |=> (rsp_outcome == OC_BYPASS && rsp_event == '0)); // R5
  AST_STAGE2_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ent_vld && ent_cfg[CFG_S2_BIT]) |=> (rsp_outcome == OC_FAULT && rsp_reason == RS_STAGE2)); // R6
  AST_GOOD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_outcome != OC_FAULT) |-> (rsp_event == '0 && rsp_reason == RS_NONE)); // R10

endmodule

bind ste_cfg_check ste_cfg_check_sva #(
  .EVT_W   (EVT_W),
  .EVT_BAD (EVT_BAD)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .take        (take),
  .ent_vld     (ent_vld),
  .ent_cfg     (ent_cfg),
  .abort_hit   (abort_hit),
  .bypass_hit  (bypass_hit),
  .rsp_valid   (rsp_valid),
  .rsp_outcome (rsp_outcome),
  .rsp_reason  (rsp_reason),
  .rsp_event   (rsp_event)
);

// File: tb/ste_cfg_check_test.sv
`timescale 1ns/1ps
module ste_cfg_check_test;

  localparam int EW = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [EW-1:0] req_entry = '0;
  logic          rsp_valid;
  logic [1:0]    rsp_outcome;
  logic [2:0]    rsp_reason;
  logic [7:0]    rsp_event;
  logic [EW-1:0] rsp_entry;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  ste_cfg_check uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_entry(req_entry), .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome),
    .rsp_reason(rsp_reason), .rsp_event(rsp_event), .rsp_entry(rsp_entry)
  );

  // Row: {valid, cfg[2:0], cdmax[4:0], stall, exp_outcome[1:0], exp_reason[2:0]}
  localparam int NV = 14;
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 3'b100, 5'd0,  1'b0, 2'd3, 3'd1},  // R3 invalid with bypass code
    {1'b0, 3'b000, 5'd0,  1'b0, 2'd3, 3'd1},  // R3 invalid with abort code
    {1'b1, 3'b000, 5'd0,  1'b0, 2'd0, 3'd0},  // R4 abort
    {1'b1, 3'b000, 5'd3,  1'b1, 2'd0, 3'd0},  // R4 abort ignores defects
    {1'b1, 3'b100, 5'd0,  1'b0, 2'd1, 3'd0},  // R5 bypass
    {1'b1, 3'b100, 5'd31, 1'b1, 2'd1, 3'd0},  // R5 bypass ignores defects
    {1'b1, 3'b001, 5'd0,  1'b0, 2'd2, 3'd0},  // R10 stage-1
    {1'b1, 3'b101, 5'd0,  1'b0, 2'd2, 3'd0},  // R10 stage-1 with bit 2
    {1'b1, 3'b011, 5'd0,  1'b0, 2'd3, 3'd2},  // R6 both stages
    {1'b1, 3'b010, 5'd0,  1'b0, 2'd3, 3'd2},  // R6 stage-2 only
    {1'b1, 3'b001, 5'd1,  1'b0, 2'd3, 3'd3},  // R7 context count
    {1'b1, 3'b001, 5'd0,  1'b1, 2'd3, 3'd4},  // R8 stall
    {1'b1, 3'b111, 5'd2,  1'b1, 2'd3, 3'd2},  // R9 stage-2 beats others
    {1'b1, 3'b001, 5'd16, 1'b1, 2'd3, 3'd3}   // R9 context beats stall
  };

  function automatic logic [EW-1:0] mk(input int seed, input logic v, input logic [2:0] c,
                                       input logic [4:0] cd, input logic st);
    logic [EW-1:0] e;
    e = {4{32'h5A3C_0000 + 32'(seed * 7919)}};
    e[0]     = v;
    e[3:1]   = c;
    e[40:36] = cd;
    e[91]    = st;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Offer one entry when idle; returns with outputs sampled after the accepting edge.
  task automatic send(input logic [EW-1:0] e);
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready when idle", 128'(req_ready), 128'd1);
    req_valid = 1'b1;
    req_entry = e;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 128'(rsp_valid), 128'd0);
    chk(req_ready == 1'b1, "R1 req_ready in reset", 128'(req_ready), 128'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 128'(rsp_valid), 128'd0);

    for (int i = 0; i < NV; i++) begin
      logic [EW-1:0] e;
      logic [1:0]    eo;
      logic [2:0]    er;
      logic [7:0]    ev;
      e  = mk(i, VEC[i][14], VEC[i][13:11], VEC[i][10:6], VEC[i][5]);
      eo = VEC[i][4:3];
      er = VEC[i][2:0];
      ev = (eo == 2'd3) ? 8'h04 : 8'h00;
      send(e);
      chk(rsp_valid == 1'b1, $sformatf("R2 response row %0d", i), 128'(rsp_valid), 128'd1);
      chk(rsp_outcome == eo, $sformatf("R3-R10 outcome row %0d", i), 128'(rsp_outcome), 128'(eo));
      chk(rsp_reason == er, $sformatf("R9 reason row %0d", i), 128'(rsp_reason), 128'(er));
      chk(rsp_event == ev, $sformatf("R3 event row %0d", i), 128'(rsp_event), 128'(ev));
      chk(rsp_entry == e, $sformatf("R12 entry row %0d", i), rsp_entry, e);
      @(negedge clk);
      chk(rsp_valid == 1'b0, $sformatf("R2 one-shot row %0d", i), 128'(rsp_valid), 128'd0);
    end

    // R11: request during the busy cycle is dropped
    send(mk(50, 1'b1, 3'b100, 5'd0, 1'b0));
    chk(req_ready == 1'b0, "R2 not ready while responding", 128'(req_ready), 128'd0);
    req_valid = 1'b1;
    req_entry = mk(51, 1'b0, 3'b000, 5'd0, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b0, "R11 busy request ignored", 128'(rsp_valid), 128'd0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 no late response", 128'(rsp_valid), 128'd0);

    // R2: request held high gives a response every other cycle
    req_valid = 1'b1;
    req_entry = mk(60, 1'b1, 3'b001, 5'd0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(rsp_valid == ((k % 2) == 0), $sformatf("R2 held request step %0d", k),
          128'(rsp_valid), 128'((k % 2) == 0));
    end
    req_valid = 1'b0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule